// File: doc/BRIEF.md
# Infrared SIR line interface

This block sits between the serial pins of a UART and an infrared transceiver. In the transmit direction it turns every zero bit on the UART output into one short active-high light pulse at the start of the bit cell. A one bit sends no pulse. In the receive direction it turns each incoming pulse back into a zero bit that is as wide as the UART expects. The absence of pulses reads as an idle one. Timing comes from a 16x oversample tick shared with the UART, which the UART also uses to change its output bits, and from the system clock.

Control inputs select the mode and the options. Mode `0X` is off: both directions pass straight through, with no inversion and no encoding. Mode `10` sends a pulse of a fixed number of system clocks, set to about 1.6 µs at the system clock rate. Mode `11` sends a pulse of 3/16 of a bit cell. Other inputs set half or full duplex (full duplex is used for self-test loopback), invert the transmit pin, invert the receive pin, and enable an optional quiet gap of four character times after reception before transmission may start.

The design has three state machines:
- **Encoder.** `ENC_IDLE` goes to `ENC_PULSE` on a start request. `ENC_PULSE` goes to `ENC_GAP` when the width expires. From `ENC_PULSE` or `ENC_GAP`, the end of the cell goes to `ENC_PULSE` again if a new start is requested, or to `ENC_IDLE` if not.
- **Decoder.** `DEC_IDLE` goes to `DEC_ZERO` on an accepted pulse edge. A new edge restarts `DEC_ZERO`. `DEC_ZERO` returns to `DEC_IDLE` when its hold count expires, or at once on mute or disable.
- **Gap timer.** `GAP_OPEN` goes to `GAP_WAIT` on an accepted edge. `GAP_WAIT` returns to `GAP_OPEN` on its last tick, or when the gap is disabled.

Top module: `ir_sir_line`

## Requirements
- R1: After reset, with IR mode on, `ir_txd` equals `tx_invert`, `uart_rxd` is 1 and `tx_permit` is 1. With mode `00`, both outputs follow their pass-through inputs.
- R2: When `ir_mode[1]` is 0, `ir_txd` equals `uart_txd` and `uart_rxd` equals `ir_rxd` in the same cycle. The invert inputs have no effect in this mode.
- R3: With IR on, a clock edge that samples `uart_txd` low while `tx_permit` is high and the encoder is idle makes the pulse active from that edge. A bit cell lasts 16 ticks from its start. If `uart_txd` is low at the last tick of a cell, the next pulse starts at once. A one bit gives no pulse.
- R4: In mode `10`, the pulse stays active for exactly `PULSE_CLKS` system clocks.
- R5: In mode `11`, the pulse ends at the edge where the encoder sees the third oversample tick after the pulse began. That is 3 tick periods when the pulse starts on a tick edge.
- R6: With IR on and `tx_invert` high, `ir_txd` is the complement of the pulse, so the idle level is 1.
- R7: `rx_invert` complements `ir_rxd` before decoding. With it set, an idle-high pin with low pulses decodes like an idle-low pin with high pulses.
- R8: A rising edge of the received pulse drives `uart_rxd` low three clock edges after it reaches the pin. The pin passes a two-flop synchronizer and an edge detector. `uart_rxd` stays low until `RX_HOLD_TICKS` ticks pass with no new edge.
- R9: In half duplex, `uart_rxd` is held at 1 and received edges are ignored while the encoder is busy. In full duplex, the block's own looped-back pulses are decoded.
- R10: With `turn_delay_en` high, each accepted received edge loads a gap of 4 character times (4 × 10 × 16 ticks). While the gap runs, `tx_permit` is 0 and no new bit cell starts.
- R11: With `turn_delay_en` low, received edges never lower `tx_permit`, and transmission starts without waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | One-clock pulse at 16 times the baud rate |
| ir_mode | input | 2 | `0X` off, `10` fixed-width pulse, `11` 3/16 pulse |
| half_duplex | input | 1 | 1 mutes reception while sending |
| tx_invert | input | 1 | Complement the infrared transmit pin |
| rx_invert | input | 1 | Complement the infrared receive pin |
| turn_delay_en | input | 1 | Enable the receive-to-transmit quiet gap |
| uart_txd | input | 1 | Serial output of the UART |
| uart_rxd | output | 1 | Decoded serial input to the UART |
| ir_txd | output | 1 | Drive to the infrared emitter |
| ir_rxd | input | 1 | Signal from the infrared detector |
| tx_permit | output | 1 | 0 while the quiet gap blocks transmission |

## Verification
The timing of each result is as follows:
- Pass-through and pin inversion appear in the same cycle as their inputs.
- An encoder pulse appears one edge after `uart_txd` is sampled low.
- A decoded zero, and the drop of `tx_permit`, appear three edges after a pulse reaches `ir_rxd`.

The bench drives inputs just after a falling edge and updates a behavioural model on each rising edge. It compares all three outputs a quarter period after every rising edge, so every register on each path has settled. Directed measurements cover pulse widths, the span of a decoded zero run, the echo mute and the length of the quiet gap. They count samples taken at the same point in the cycle.

// File: rtl/ir_sir_pkg.sv
package ir_sir_pkg;

    typedef enum logic [1:0] {
        ENC_IDLE  = 2'd0,
        ENC_PULSE = 2'd1,
        ENC_GAP   = 2'd2
    } enc_state_e;

    typedef enum logic {
        DEC_IDLE = 1'b0,
        DEC_ZERO = 1'b1
    } dec_state_e;

    typedef enum logic {
        GAP_OPEN = 1'b0,
        GAP_WAIT = 1'b1
    } gap_state_e;

endpackage

// File: rtl/ir_sir_tx_enc.sv
module ir_sir_tx_enc
    import ir_sir_pkg::*;
#(
    parameter int unsigned PULSE_CLKS = 77,
    parameter int unsigned OVS        = 16,
    parameter int unsigned FRAC_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic frac_i,
    input  logic tick_i,
    input  logic go_i,
    output logic pulse_o,
    output logic busy_o
);

    localparam int unsigned CELL_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int unsigned PW_W   = $clog2(PULSE_CLKS + 1);
    localparam int unsigned FT_W   = $clog2(FRAC_TICKS + 1);

    enc_state_e       st_q, st_d;
    logic [CELL_W-1:0] cell_q;
    logic [PW_W-1:0]   pw_q;
    logic [FT_W-1:0]   ft_q;
    logic              cell_last, width_last, start;

    always_comb begin
        cell_last  = tick_i && (cell_q == CELL_W'(OVS - 1));
        width_last = frac_i ? (tick_i && (ft_q == FT_W'(FRAC_TICKS - 1)))
                            : (pw_q == PW_W'(PULSE_CLKS - 1));
    end

    // next-state logic
    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (!enable_i) begin
            st_d = ENC_IDLE;
        end else begin
            unique case (st_q)
                ENC_IDLE: begin
                    if (go_i) begin
                        st_d  = ENC_PULSE;
                        start = 1'b1;
                    end
                end
                ENC_PULSE: begin
                    if (cell_last) begin
                        if (go_i) begin
                            st_d  = ENC_PULSE;
                            start = 1'b1;
                        end else begin
                            st_d = ENC_IDLE;
                        end
                    end else if (width_last) begin
                        st_d = ENC_GAP;
                    end
                end
                ENC_GAP: begin
                    if (cell_last) begin
                        if (go_i) begin
                            st_d  = ENC_PULSE;
                            start = 1'b1;
                        end else begin
                            st_d = ENC_IDLE;
                        end
                    end
                end
                default: st_d = ENC_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ENC_IDLE;
        else        st_q <= st_d;
    end

    // cell and width counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
            pw_q   <= '0;
            ft_q   <= '0;
        end else begin
            if (start || st_d == ENC_IDLE) cell_q <= '0;
            else if (tick_i)               cell_q <= cell_q + 1'b1;

            if (start) pw_q <= '0;
            else if (st_q == ENC_PULSE && pw_q != PW_W'(PULSE_CLKS)) pw_q <= pw_q + 1'b1;

            if (start) ft_q <= '0;
            else if (st_q == ENC_PULSE && tick_i && ft_q != FT_W'(FRAC_TICKS)) ft_q <= ft_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        pulse_o = (st_q == ENC_PULSE);
        busy_o  = (st_q != ENC_IDLE);
    end

    // R3: a pulse only begins after a start request
    p_pulse_from_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(go_i));

    // R4: a fixed pulse is not cut short before its count
    p_fixed_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ENC_PULSE && enable_i && !frac_i && !cell_last
         && pw_q < PW_W'(PULSE_CLKS - 1)) |=> pulse_o);

    // R5: in fractional mode a pulse only ends on a tick
    p_frac_end_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_o) && $past(enable_i && frac_i)) |-> $past(tick_i));

endmodule

// File: rtl/ir_sir_rx_dec.sv
module ir_sir_rx_dec
    import ir_sir_pkg::*;
#(
    parameter int unsigned HOLD_TICKS = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic mute_i,
    input  logic tick_i,
    input  logic rx_i,
    output logic zero_o,
    output logic edge_o
);

    localparam int unsigned HW = $clog2(HOLD_TICKS + 1);

    dec_state_e    st_q, st_d;
    logic [HW-1:0] hold_q;
    logic          sync1_q, sync2_q, prev_q;
    logic          rise, accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= rx_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    always_comb begin
        rise   = sync2_q && !prev_q;
        accept = enable_i && !mute_i && rise;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (!enable_i || mute_i) begin
            st_d = DEC_IDLE;
        end else begin
            unique case (st_q)
                DEC_IDLE: if (accept) st_d = DEC_ZERO;
                DEC_ZERO: begin
                    if (accept)                                         st_d = DEC_ZERO;
                    else if (tick_i && hold_q == HW'(HOLD_TICKS - 1))  st_d = DEC_IDLE;
                end
                default: st_d = DEC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DEC_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              hold_q <= '0;
        else if (accept)                         hold_q <= '0;
        else if (st_q == DEC_ZERO && tick_i)     hold_q <= hold_q + 1'b1;
    end

    always_comb begin
        zero_o = (st_q == DEC_ZERO);
        edge_o = accept;
    end

    // R8: a decoded zero only begins on a synchronized rising edge
    p_zero_needs_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_o) |-> $past(rise));

    // R9: muting leaves the decoder idle on the next cycle
    p_mute_silences_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mute_i |=> !zero_o);

endmodule

// File: rtl/ir_sir_turn_gap.sv
module ir_sir_turn_gap
    import ir_sir_pkg::*;
#(
    parameter int unsigned GAP_TICKS = 640
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic load_i,
    input  logic tick_i,
    output logic block_o
);

    localparam int unsigned GW = $clog2(GAP_TICKS + 1);

    gap_state_e    st_q, st_d;
    logic [GW-1:0] cnt_q;

    always_comb begin
        st_d = st_q;
        if (!enable_i) begin
            st_d = GAP_OPEN;
        end else begin
            unique case (st_q)
                GAP_OPEN: if (load_i) st_d = GAP_WAIT;
                GAP_WAIT: begin
                    if (load_i)                            st_d = GAP_WAIT;
                    else if (tick_i && cnt_q == GW'(1))    st_d = GAP_OPEN;
                end
                default: st_d = GAP_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GAP_OPEN;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               cnt_q <= '0;
        else if (!enable_i)                       cnt_q <= '0;
        else if (load_i)                          cnt_q <= GW'(GAP_TICKS);
        else if (st_q == GAP_WAIT && tick_i)      cnt_q <= cnt_q - 1'b1;
    end

    always_comb block_o = (st_q == GAP_WAIT);

    // R10: the gap count never grows except on a reload
    p_gap_shrinks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GAP_WAIT && enable_i && !load_i) |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/ir_sir_line.sv
module ir_sir_line
    import ir_sir_pkg::*;
#(
    parameter int unsigned PULSE_CLKS    = 77,
    parameter int unsigned OVS           = 16,
    parameter int unsigned FRAC_TICKS    = 3,
    parameter int unsigned CHAR_BITS     = 10,
    parameter int unsigned TURN_CHARS    = 4,
    parameter int unsigned RX_HOLD_TICKS = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic [1:0] ir_mode,
    input  logic       half_duplex,
    input  logic       tx_invert,
    input  logic       rx_invert,
    input  logic       turn_delay_en,
    input  logic       uart_txd,
    output logic       uart_rxd,
    output logic       ir_txd,
    input  logic       ir_rxd,
    output logic       tx_permit
);

    localparam int unsigned TURN_TICKS = TURN_CHARS * CHAR_BITS * OVS;

    logic ir_on, frac_sel, permit, go, mute, rx_line;
    logic enc_pulse, enc_busy, dec_zero, dec_edge, gap_block;

    always_comb begin
        ir_on    = ir_mode[1];
        frac_sel = ir_mode[0];
        permit   = !(ir_on && turn_delay_en && gap_block);
        go       = !uart_txd && permit;
        mute     = half_duplex && enc_busy;
        rx_line  = ir_rxd ^ rx_invert;
    end

    ir_sir_tx_enc #(
        .PULSE_CLKS (PULSE_CLKS),
        .OVS        (OVS),
        .FRAC_TICKS (FRAC_TICKS)
    ) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (ir_on),
        .frac_i   (frac_sel),
        .tick_i   (os_tick),
        .go_i     (go),
        .pulse_o  (enc_pulse),
        .busy_o   (enc_busy)
    );

    ir_sir_rx_dec #(
        .HOLD_TICKS (RX_HOLD_TICKS)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (ir_on),
        .mute_i   (mute),
        .tick_i   (os_tick),
        .rx_i     (rx_line),
        .zero_o   (dec_zero),
        .edge_o   (dec_edge)
    );

    ir_sir_turn_gap #(
        .GAP_TICKS (TURN_TICKS)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (ir_on && turn_delay_en),
        .load_i   (dec_edge),
        .tick_i   (os_tick),
        .block_o  (gap_block)
    );

    always_comb begin
        ir_txd    = ir_on ? (enc_pulse ^ tx_invert) : uart_txd;
        uart_rxd  = ir_on ? (mute ? 1'b1 : !dec_zero) : ir_rxd;
        tx_permit = permit;
    end

    // R10: while the gap blocks, an idle encoder stays idle
    p_permit_holds_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enc_busy && !tx_permit) |=> !enc_busy);

endmodule

// File: tb/sim_ir_sir_line.sv
`timescale 1ns/1ps
module sim_ir_sir_line;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int PCLK       = 5;
    localparam int CELL       = 16;
    localparam int FRAC       = 3;
    localparam int HOLD       = 18;
    localparam int TURN       = 4 * 10 * 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic       os_tick = 1'b0;
    int         divc = 0;
    logic [1:0] mode = 2'b00;
    logic       half = 1'b1, txinv = 1'b0, rxinv = 1'b0, turn_en = 1'b0;
    logic       utx = 1'b1, pin_drv = 1'b0, loopb = 1'b0;
    logic       ir_rxd, ir_txd, uart_rxd, tx_permit;

    assign ir_rxd = loopb ? ir_txd : pin_drv;

    always @(negedge clk) begin
        if (divc == DIV - 1) begin divc <= 0; os_tick <= 1'b1; end
        else begin divc <= divc + 1; os_tick <= 1'b0; end
    end

    ir_sir_line #(.PULSE_CLKS(PCLK)) u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .ir_mode(mode),
        .half_duplex(half), .tx_invert(txinv), .rx_invert(rxinv),
        .turn_delay_en(turn_en), .uart_txd(utx), .uart_rxd(uart_rxd),
        .ir_txd(ir_txd), .ir_rxd(ir_rxd), .tx_permit(tx_permit)
    );

    int    tests = 0, fails = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_busy, m_puls, m_cell, m_pw, m_ft, m_zero, m_hc, m_left;
    int s1, s2, s3;

    function automatic void model_outs(output logic e_tx, output logic e_rx, output logic e_pm);
        logic on, pin;
        on   = mode[1];
        e_tx = on ? (logic'(m_puls != 0) ^ txinv) : utx;
        pin  = loopb ? e_tx : pin_drv;
        e_rx = on ? ((half && m_busy != 0) ? 1'b1 : logic'(m_zero == 0)) : pin;
        e_pm = !(on && turn_en && m_left > 0);
    endfunction

    always @(posedge clk) begin
        logic etx, erx, epm, pin, go, rise, mute, acc, en;
        if (!rst_n) begin
            m_busy = 0; m_puls = 0; m_cell = 0; m_pw = 0; m_ft = 0;
            m_zero = 0; m_hc = 0; m_left = 0; s1 = 0; s2 = 0; s3 = 0;
        end else begin
            model_outs(etx, erx, epm);
            pin  = loopb ? etx : pin_drv;
            go   = !utx && epm;
            rise = (s2 != 0) && (s3 == 0);
            mute = half && (m_busy != 0);
            acc  = mode[1] && !mute && rise;
            en   = mode[1] && turn_en;
            // transmit side
            if (!mode[1]) begin
                m_busy = 0; m_puls = 0; m_cell = 0;
            end else if (m_busy == 0) begin
                if (go) begin m_busy = 1; m_puls = 1; m_cell = 0; m_pw = 0; m_ft = 0; end
            end else if (os_tick && m_cell == CELL - 1) begin
                if (go) begin m_puls = 1; m_cell = 0; m_pw = 0; m_ft = 0; end
                else begin m_busy = 0; m_puls = 0; m_cell = 0; end
            end else begin
                if (os_tick) m_cell++;
                if (m_puls != 0) begin
                    if (mode[0]) begin
                        if (os_tick) begin m_ft++; if (m_ft == FRAC) m_puls = 0; end
                    end else begin
                        if (m_pw == PCLK - 1) m_puls = 0; else m_pw++;
                    end
                end
            end
            // receive side
            if (!mode[1] || mute) m_zero = 0;
            else if (acc) begin m_zero = 1; m_hc = 0; end
            else if (m_zero != 0 && os_tick) begin m_hc++; if (m_hc == HOLD) m_zero = 0; end
            // quiet gap
            if (!en) m_left = 0;
            else if (acc) m_left = TURN;
            else if (os_tick && m_left > 0) m_left--;
            s3 = s2; s2 = s1; s1 = int'(pin ^ rxinv);
        end
    end

    // cycle compare, a quarter period after each rising edge
    always begin
        logic etx, erx, epm;
        @(posedge clk);
        #(CLK_PERIOD / 4);
        if (rst_n && !done) begin
            model_outs(etx, erx, epm);
            tests++;
            if (ir_txd !== etx || uart_rxd !== erx || tx_permit !== epm) begin
                fails++;
                $display("FAIL %s cycle compare: tx/rx/permit actual %b%b%b expected %b%b%b",
                         cur_req, ir_txd, uart_rxd, tx_permit, etx, erx, epm);
            end
        end
    end

    task automatic check(input string req, input int act, input int lo, input int hi);
        tests++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    // wait until a tick is due at the next rising edge
    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk); #1;
            while (!os_tick) begin @(negedge clk); #1; end
        end
    endtask

    // which: 0 active ir_txd, 1 low uart_rxd, 2 low tx_permit
    task automatic count_smp(input int which, input int window, output int n);
        n = 0;
        repeat (window) begin
            @(posedge clk); #(CLK_PERIOD / 4);
            case (which)
                0: if (ir_txd ^ txinv) n++;
                1: if (!uart_rxd) n++;
                default: if (!tx_permit) n++;
            endcase
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic [9:0] fr;
        fr = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            ticks(1); utx = fr[i];
            ticks(CELL - 1);
        end
        utx = 1'b1;
    endtask

    task automatic rx_byte(input logic [7:0] b, input logic idle_lvl);
        logic [9:0] fr;
        fr = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            ticks(1);
            if (!fr[i]) begin
                pin_drv = !idle_lvl; ticks(FRAC); pin_drv = idle_lvl; ticks(CELL - FRAC - 1);
            end else begin
                ticks(CELL - 1);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired before the end of the run");
        finish_run();
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #(CLK_PERIOD / 4);
        // R1: mode 00 after reset passes pins through
        check("R1 reset pass ir_txd", int'(ir_txd), 1, 1);
        check("R1 reset pass uart_rxd", int'(uart_rxd), 0, 0);
        @(negedge clk); mode = 2'b10;
        @(posedge clk); #(CLK_PERIOD / 4);
        check("R1 idle ir_txd", int'(ir_txd), 0, 0);
        check("R1 idle uart_rxd", int'(uart_rxd), 1, 1);
        check("R1 idle permit", int'(tx_permit), 1, 1);

        // R2: pass-through ignores inversion
        cur_req = "R2";
        @(negedge clk); mode = 2'b00; txinv = 1'b1; rxinv = 1'b1; utx = 1'b0; pin_drv = 1'b1;
        @(posedge clk); #(CLK_PERIOD / 4);
        check("R2 ir_txd follows uart_txd", int'(ir_txd), 0, 0);
        check("R2 uart_rxd follows ir_rxd", int'(uart_rxd), 1, 1);
        @(negedge clk); utx = 1'b1; pin_drv = 1'b0; txinv = 1'b0; rxinv = 1'b0;
        repeat (3) @(negedge clk);

        // R4: fixed-width pulse
        cur_req = "R4";
        mode = 2'b10;
        ticks(2); utx = 1'b0;
        count_smp(0, CELL * DIV - 2, n); utx = 1'b1;
        check("R4 fixed pulse width", n, PCLK, PCLK);
        ticks(CELL);

        // R5: 3/16 pulse
        cur_req = "R5";
        mode = 2'b11;
        ticks(1); utx = 1'b0;
        count_smp(0, CELL * DIV - 2, n); utx = 1'b1;
        check("R5 fractional pulse width", n, FRAC * DIV, FRAC * DIV);
        ticks(CELL);

        // R3: one bits send nothing, only the start bit pulses
        cur_req = "R3";
        mode = 2'b10;
        fork send_byte(8'hFF); count_smp(0, 10 * CELL * DIV, n); join
        check("R3 only start bit pulses", n, PCLK, PCLK);
        fork send_byte(8'h00); count_smp(0, 10 * CELL * DIV, n); join
        check("R3 nine zero cells", n, 9 * PCLK, 9 * PCLK);
        send_byte(8'hA5);
        ticks(CELL);

        // R6: inverted transmit pin
        cur_req = "R6";
        txinv = 1'b1;
        @(posedge clk); #(CLK_PERIOD / 4);
        check("R6 inverted idle level", int'(ir_txd), 1, 1);
        fork send_byte(8'h3C); count_smp(0, 10 * CELL * DIV, n); join
        check("R6 inverted pulses", n, 5 * PCLK, 5 * PCLK);
        txinv = 1'b0;
        ticks(CELL);

        // R8: consecutive zeros decode as one continuous low run
        cur_req = "R8";
        fork rx_byte(8'h00, 1'b0); count_smp(1, 10 * CELL * DIV, n); join
        check("R8 zero run span", n, 9 * CELL * DIV - 4, 9 * CELL * DIV + HOLD * DIV);
        rx_byte(8'h96, 1'b0);
        ticks(2 * CELL);

        // R7: inverted receive pin, idle high with low pulses
        cur_req = "R7";
        rxinv = 1'b1; pin_drv = 1'b1;
        ticks(CELL);
        fork rx_byte(8'hF0, 1'b1); count_smp(1, 10 * CELL * DIV, n); join
        check("R7 inverted input decodes", n, 5 * CELL * DIV - 4, 5 * CELL * DIV + HOLD * DIV);
        rxinv = 1'b0; pin_drv = 1'b0;
        ticks(2 * CELL);

        // R9: echo muted in half duplex, heard in full duplex
        cur_req = "R9";
        loopb = 1'b1; half = 1'b1;
        fork send_byte(8'h00); count_smp(1, 10 * CELL * DIV, n); join
        check("R9 half duplex echo muted", n, 0, 0);
        ticks(2 * CELL);
        half = 1'b0;
        fork send_byte(8'h00); count_smp(1, 10 * CELL * DIV, n); join
        check("R9 full duplex loopback heard", n, 1, 10 * CELL * DIV);
        ticks(2 * CELL);
        loopb = 1'b0; half = 1'b1;
        ticks(2 * CELL);

        // R10: quiet gap after reception blocks transmission
        cur_req = "R10";
        turn_en = 1'b1;
        ticks(1); pin_drv = 1'b1; ticks(FRAC); pin_drv = 1'b0;
        @(posedge clk); #(CLK_PERIOD / 4);
        check("R10 permit dropped", int'(tx_permit), 0, 0);
        @(negedge clk); utx = 1'b0;
        count_smp(0, 2000, n);
        check("R10 no pulse inside gap", n, 0, 0);
        @(negedge clk); utx = 1'b1;
        n = 0;
        while (!tx_permit && n < 3 * TURN * DIV) begin
            @(posedge clk); #(CLK_PERIOD / 4); n++;
        end
        check("R10 gap length", 2000 + n, TURN * DIV - FRAC * DIV - 8, TURN * DIV);
        fork send_byte(8'h0F); count_smp(0, 10 * CELL * DIV, n); join
        check("R10 sends after gap", n, 5 * PCLK, 5 * PCLK);
        ticks(CELL);

        // R11: no gap when disabled
        cur_req = "R11";
        turn_en = 1'b0;
        fork rx_byte(8'h00, 1'b0); count_smp(2, 10 * CELL * DIV, n); join
        check("R11 permit never drops", n, 0, 0);
        ticks(1); utx = 1'b0;
        count_smp(0, CELL * DIV - 2, n); utx = 1'b1;
        check("R11 immediate transmit", n, PCLK, PCLK);
        ticks(2 * CELL);

        finish_run();
    end

endmodule